// File: doc/BRIEF.md
# Packed FP4 Block Dequantizer

This block turns a stream of packed 4-bit floating-point weights back into signed fixed-point numbers. Every input byte carries two element codes. Each code has a sign bit, a 2-bit exponent and a 1-bit mantissa. Every run of sixteen elements, which is eight bytes, shares one 8-bit scale. That scale is an 8-bit float with 4 exponent bits and 3 mantissa bits. A tensor-wide global factor multiplies every element as well. Each reconstructed element is the code value times the block scale times the global factor.

Packed bytes arrive on a valid/ready input. The block scale is presented together with the first byte of each block. Elements leave one per cycle on a valid/ready output, in stream order. The global factor is an unsigned integer. Its binary point is the user's choice. The output carries ten more fraction bits than that integer, so every product is exact. A scale byte that encodes NaN is reported on a flag that travels alongside each affected element.

Top module: `fp4blk_dequant`

## Requirements
- R1: During reset and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: The element in the low nibble (bits 3:0) of a byte is output before the element in the high nibble (bits 7:4). Bytes leave in the order they were accepted.
- R3: An element code has its sign in bit 3, its exponent in bits 2:1 and its mantissa in bit 0. Codes 0 to 7 of the three low bits give the magnitudes 0, 0.5, 1, 1.5, 2, 3, 4 and 6. A set sign bit negates the value, and negative zero gives 0.
- R4: A scale byte has its sign in bit 7, its exponent e in bits 6:3 (bias 7) and its mantissa m in bits 2:0. For e ≥ 1 its value is (1+m/8)·2^(e−7). For e = 0 its value is (m/8)·2^−6. The largest value is 448.
- R5: A scale whose bits 6:0 are all ones is NaN. All sixteen elements of that block then leave with `out_nan` = 1 and `out_value` = 0. All other elements leave with `out_nan` = 0.
- R6: `out_value`·2^−10 equals element × scale × `gscale`, exactly, as a signed two's-complement number of width 23+GS_W. It never exceeds 6·448·(2^GS_W−1) in magnitude.
- R7: `in_scale` is captured only with the first byte of each eight-byte block. Its value with the other seven bytes has no effect.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_value` hold. No element is lost or duplicated under any pattern of stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Packed byte offered |
| in_ready | output | 1 | Packed byte accepted this cycle when valid |
| in_byte | input | 8 | Two element codes, low nibble first |
| in_scale | input | 8 | Block scale, sampled with the first byte of a block |
| gscale | input | GS_W | Unsigned global factor |
| out_valid | output | 1 | Element available |
| out_ready | input | 1 | Downstream takes the element |
| out_value | output | GS_W+23 | Signed fixed-point element, 10 fraction bits beyond gscale |
| out_nan | output | 1 | Element belongs to a NaN-scaled block |

## Verification
The bench builds the block with its defaults: sixteen elements per block and a 16-bit global factor. This gives 39-bit outputs, which a 64-bit reference holds exactly. With these values, a global factor of all ones combined with the 448 scale and the magnitude-6 code reaches the top of the output range. The eight-byte block counter wraps several times within one run, so scale capture at the boundary and the ignored mid-block scale inputs are both exercised. The runs alternate between full-throughput phases and phases with random stalls on both sides.

// File: rtl/fp4dq_pkg.sv
package fp4dq_pkg;

    localparam int HALF_W = 4;               // element magnitude in units of 0.5
    localparam int SC_W   = 18;              // scale magnitude in units of 2^-9
    localparam int MAG_W  = HALF_W + SC_W;   // product in units of 2^-10

    typedef struct packed {
        logic       sgn;
        logic [1:0] ex;
        logic       man;
    } e2m1_t;

    typedef struct packed {
        logic       sgn;
        logic [3:0] ex;
        logic [2:0] man;
    } e4m3_t;

    typedef struct packed {
        e2m1_t code;
        e4m3_t scale;
    } elem_t;

    function automatic logic [HALF_W-1:0] e2m1_half(input e2m1_t c);
        logic [HALF_W-1:0] r;
        case ({c.ex, c.man})
            3'd0:    r = 4'd0;
            3'd1:    r = 4'd1;
            3'd2:    r = 4'd2;
            3'd3:    r = 4'd3;
            3'd4:    r = 4'd4;
            3'd5:    r = 4'd6;
            3'd6:    r = 4'd8;
            default: r = 4'd12;
        endcase
        return r;
    endfunction

    function automatic logic [SC_W-1:0] e4m3_mag(input e4m3_t s);
        if (s.ex == 4'd0)
            return SC_W'(s.man);
        return SC_W'({1'b1, s.man}) << (s.ex - 4'd1);
    endfunction

    function automatic logic e4m3_is_nan(input e4m3_t s);
        return &{s.ex, s.man};
    endfunction

endpackage

// File: rtl/fp4dq_unpack.sv
module fp4dq_unpack
    import fp4dq_pkg::*;
#(
    parameter int BLK_ELEMS = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [7:0]  in_byte,
    input  logic [7:0]  in_scale,
    output logic        el_valid,
    input  logic        el_ready,
    output elem_t       el
);
    localparam int BYTES = BLK_ELEMS / 2;
    localparam int CNT_W = (BYTES > 1) ? $clog2(BYTES) : 1;

    logic             hold_v;
    logic             phase;      // 0: low nibble next, 1: high nibble next
    logic [7:0]       hold_byte;
    e4m3_t            blk_sc;
    logic [CNT_W-1:0] cnt;
    logic             take, accept;

    assign el_valid = hold_v;
    assign take     = el_valid && el_ready;
    assign in_ready = !hold_v || (take && phase);
    assign accept   = in_valid && in_ready;

    always_comb begin
        el.code  = phase ? e2m1_t'(hold_byte[7:4]) : e2m1_t'(hold_byte[3:0]);
        el.scale = blk_sc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_v    <= 1'b0;
            phase     <= 1'b0;
            hold_byte <= '0;
            blk_sc    <= '0;
            cnt       <= '0;
        end else if (accept) begin
            hold_byte <= in_byte;
            hold_v    <= 1'b1;
            phase     <= 1'b0;
            if (cnt == '0)
                blk_sc <= e4m3_t'(in_scale);
            cnt <= (cnt == CNT_W'(BYTES - 1)) ? '0 : cnt + 1'b1;
        end else if (take) begin
            if (phase) begin
                hold_v <= 1'b0;
                phase  <= 1'b0;
            end else begin
                phase <= 1'b1;
            end
        end
    end

    // R2: once the low nibble has gone, the high nibble of the same byte is next
    p_high_follows_r2: assert property (@(posedge clk) disable iff (rst)
        (take && !phase) |=> (hold_v && phase));

    // R2: no new byte may overwrite a byte whose high nibble is still pending
    p_no_overwrite_r2: assert property (@(posedge clk) disable iff (rst)
        (hold_v && !(take && phase)) |-> !in_ready);

    // R7: a byte inside a block leaves the captured scale untouched
    p_scale_kept_r7: assert property (@(posedge clk) disable iff (rst)
        (accept && cnt != '0) |=> $stable(blk_sc));

endmodule

// File: rtl/fp4dq_outstage.sv
module fp4dq_outstage
    import fp4dq_pkg::*;
#(
    parameter int GS_W  = 16,
    parameter int OUT_W = MAG_W + GS_W + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    el_valid,
    output logic                    el_ready,
    input  elem_t                   el,
    input  logic [GS_W-1:0]         gscale,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic signed [OUT_W-1:0] out_value,
    output logic                    out_nan
);
    localparam int FULL_W = MAG_W + GS_W;
    localparam logic signed [OUT_W-1:0] LIMIT =
        OUT_W'(12) * OUT_W'(229376) * OUT_W'({GS_W{1'b1}});

    logic [MAG_W-1:0]         mag;
    logic [FULL_W-1:0]        full;
    logic                     neg, nan;
    logic signed [OUT_W-1:0]  nxt;

    always_comb begin
        mag  = MAG_W'(e2m1_half(el.code)) * MAG_W'(e4m3_mag(el.scale));
        full = FULL_W'(mag) * FULL_W'(gscale);
        neg  = el.code.sgn ^ el.scale.sgn;
        nan  = e4m3_is_nan(el.scale);
        if (nan)
            nxt = '0;
        else if (neg)
            nxt = -$signed({1'b0, full});
        else
            nxt = $signed({1'b0, full});
    end

    assign el_ready = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_value <= '0;
            out_nan   <= 1'b0;
        end else if (el_ready) begin
            out_valid <= el_valid;
            if (el_valid) begin
                out_value <= nxt;
                out_nan   <= nan;
            end
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk) rst |=> !out_valid);

    p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_value) && $stable(out_nan)));

    p_nan_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_nan) |-> (out_value == '0));

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_value <= LIMIT && out_value >= -LIMIT));

endmodule

// File: rtl/fp4blk_dequant.sv
module fp4blk_dequant
    import fp4dq_pkg::*;
#(
    parameter int BLK_ELEMS = 16,
    parameter int GS_W      = 16,
    localparam int OUT_W    = MAG_W + GS_W + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [7:0]              in_byte,
    input  logic [7:0]              in_scale,
    input  logic [GS_W-1:0]         gscale,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic signed [OUT_W-1:0] out_value,
    output logic                    out_nan
);
    logic  el_valid, el_ready;
    elem_t el;

    fp4dq_unpack #(.BLK_ELEMS(BLK_ELEMS)) u_unpack (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_byte  (in_byte),
        .in_scale (in_scale),
        .el_valid (el_valid),
        .el_ready (el_ready),
        .el       (el)
    );

    fp4dq_outstage #(.GS_W(GS_W), .OUT_W(OUT_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .el_valid  (el_valid),
        .el_ready  (el_ready),
        .el        (el),
        .gscale    (gscale),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_value (out_value),
        .out_nan   (out_nan)
    );

endmodule

// File: tb/fp4blk_dequant_test.sv
module fp4blk_dequant_test;
    localparam int CLK_P = 10;
    localparam int GS_W  = 16;
    localparam int OUT_W = 22 + GS_W + 1;

    logic clk, rst, in_valid, in_ready, out_valid, out_ready, out_nan;
    logic [7:0] in_byte, in_scale;
    logic [GS_W-1:0] gscale;
    logic signed [OUT_W-1:0] out_value;

    fp4blk_dequant #(.BLK_ELEMS(16), .GS_W(GS_W)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_byte(in_byte), .in_scale(in_scale), .gscale(gscale),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_value(out_value), .out_nan(out_nan));

    int errors = 0, checks = 0, cycles = 0;
    bit hung = 0;
    string tag = "R1";
    logic [7:0] stim_b[$], stim_s[$];
    longint exp_v[$];
    bit exp_n[$];
    int byte_idx = 0;
    logic [7:0] mdl_scale = 8'h00;
    int rdy_pct = 100, val_pct = 100;
    bit acc_prev = 0, stall = 0;
    longint held_v;

    initial begin
        clk = 0;
        forever #(CLK_P/2) clk = ~clk;
    end

    function automatic real code_val(input logic [3:0] c);
        int e = (c >> 1) & 3;
        real mag;
        mag = (e == 0) ? 0.5 * c[0] : (1.0 + 0.5 * c[0]) * (2.0 ** (e - 1));
        return c[3] ? -mag : mag;
    endfunction

    function automatic real scale_val(input logic [7:0] s);
        int e = (s >> 3) & 15;
        int m = s & 7;
        real v;
        v = (e == 0) ? (m / 8.0) * (2.0 ** -6) : (1.0 + m / 8.0) * (2.0 ** (e - 7));
        return s[7] ? -v : v;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic add_block(input logic [7:0] sc, input logic [7:0] b[8]);
        for (int k = 0; k < 8; k++) begin
            stim_b.push_back(b[k]);
            // R7: bytes after the first carry a different, ignored scale
            stim_s.push_back(k == 0 ? sc : ~sc ^ 8'(k));
        end
    endtask

    task automatic add_rand_block(input logic [7:0] sc);
        logic [7:0] b[8];
        for (int k = 0; k < 8; k++) b[k] = 8'($urandom);
        add_block(sc, b);
    endtask

    task automatic model_byte(input logic [7:0] b, input logic [7:0] s);
        bit nan;
        if (byte_idx == 0) mdl_scale = s;
        byte_idx = (byte_idx + 1) % 8;
        nan = (mdl_scale[6:0] == 7'h7F);
        for (int h = 0; h < 2; h++) begin
            logic [3:0] c = (h == 0) ? b[3:0] : b[7:4];
            real r = code_val(c) * scale_val(mdl_scale) * real'(gscale) * 1024.0;
            exp_v.push_back(nan ? 64'sd0 : longint'(r));
            exp_n.push_back(nan);
        end
    endtask

    task automatic step();
        longint act;
        @(negedge clk);
        cycles++;
        if (cycles > 150000) begin
            hung = 1;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            return;
        end
        if (stall) begin  // R8: stalled output must hold
            act = longint'(out_value);
            check(out_valid && act == held_v, "R8 hold", act, held_v);
        end
        out_ready = ($urandom % 100) < rdy_pct;
        if (!in_valid || acc_prev) begin
            if (stim_b.size() > 0 && ($urandom % 100) < val_pct) begin
                in_byte  = stim_b.pop_front();
                in_scale = stim_s.pop_front();
                in_valid = 1;
            end else begin
                in_valid = 0;
                in_byte  = 8'($urandom);
                in_scale = 8'($urandom);
            end
        end
        #1;
        acc_prev = in_valid && in_ready;
        if (acc_prev) model_byte(in_byte, in_scale);
        stall = out_valid && !out_ready;
        if (stall) held_v = longint'(out_value);
        if (out_valid && out_ready) begin
            act = longint'(out_value);
            if (exp_v.size() == 0) begin
                check(0, "R8 extra element", act, 0);
            end else begin
                longint ev = exp_v.pop_front();
                bit en = exp_n.pop_front();
                check(act == ev, {tag, " R6 value"}, act, ev);
                check(out_nan == en, {tag, " R5 flag"}, longint'(out_nan), longint'(en));
            end
        end
    endtask

    task automatic run();
        while (!hung && (stim_b.size() > 0 || exp_v.size() > 0 || in_valid || out_valid))
            step();
    endtask

    initial begin
        logic [7:0] b[8];
        rst = 1; in_valid = 0; out_ready = 1; in_byte = 0; in_scale = 0; gscale = 16'd256;
        repeat (3) @(negedge clk);
        // R1: idle state under reset
        check(!out_valid, "R1 out_valid", longint'(out_valid), 0);
        check(in_ready, "R1 in_ready", longint'(in_ready), 1);
        rst = 0;
        @(negedge clk);
        check(!out_valid, "R1 out_valid after", longint'(out_valid), 0);
        check(in_ready, "R1 in_ready after", longint'(in_ready), 1);

        // R2 R3: every code once, low nibble k, high nibble k+8, unit scale
        tag = "R2/R3";
        for (int k = 0; k < 8; k++) b[k] = 8'((k + 8) * 16 + k);
        add_block(8'h38, b);
        run();

        // R4 R7: subnormal, min normal, max, negative and fractional scales
        tag = "R4/R7";
        add_rand_block(8'h01);
        add_rand_block(8'h08);
        add_rand_block(8'h7E);
        add_rand_block(8'hB8);
        add_rand_block(8'h3C);
        add_rand_block(8'h87);
        run();

        // R5: NaN scales of both signs, then a normal block again
        tag = "R5";
        add_rand_block(8'h7F);
        add_rand_block(8'hFF);
        add_rand_block(8'h30);
        run();

        // R6 R8: full-range global factor, extreme codes, random stalls
        tag = "R6/R8";
        gscale = 16'hFFFF;
        rdy_pct = 40; val_pct = 60;
        for (int k = 0; k < 8; k++) b[k] = (k % 2) ? 8'hFF : 8'h77;
        add_block(8'h7E, b);
        add_block(8'hFE, b);
        for (int n = 0; n < 12; n++) add_rand_block(8'($urandom) & 8'hF7);
        run();

        check(exp_v.size() == 0, "R8 drained", exp_v.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule